// File: doc/BRIEF.md
# Trap Cause Priority Arbiter

This block decides which pending trap a small in-order core takes next and reports it as a registered cause code with a pending strobe. Three kinds of source feed it: synchronous exceptions, interrupt lines, and a halt request from the debug logic. Each source is caught in a sticky buffer, so a one-cycle pulse is not lost. A debug-mode status bit from the core masks the halt request and the interrupts.

The halt request ranks above every exception. A core that traps on every fetch, for example one whose trap handler points at all-zero memory and so raises an illegal-instruction trap forever, can still be stopped by the debugger. The debug logic holds its request until the core reports debug mode, and the arbiter keeps choosing halt for that whole time. Once the core accepts the trap, the arbiter sends a one-cycle clear pulse back to the winning source only. An exception that lost to a halt stays buffered and is taken again later.

Top module: `trap_arbiter`

## Requirements
- R1: Cause codes are fixed per source. Halt gives 0x63. Exception bit 0 (fetch address misaligned) gives 0x00, bit 1 (fetch access fault) 0x01, bit 2 (illegal instruction) 0x02, bit 3 (breakpoint) 0x03, bit 4 (load/store misaligned) 0x04, bit 5 (load/store access fault) 0x05 and bit 6 (environment call) 0x0B. Interrupt line i gives 0x80 + i.
- R2: When halt and any exception are both pending and the core is not in debug mode, the cause registered is 0x63. It stays 0x63 on every later decision until debug mode is reported.
- R3: Among pending exceptions, the lowest bit index wins.
- R4: Any pending exception outranks every interrupt. Among interrupts, the lowest line index wins. Interrupts take part only while `irq_en_i` is 1.
- R5: While `debug_mode_i` is 1, halt and interrupts are ignored and only exceptions are arbitrated. A halt request seen during debug mode is discarded.
- R6: A source pulsed in the cycle before clock edge k is buffered at edge k. It appears on `trap_pend_o` and `trap_cause_o` after edge k+1.
- R7: When `trap_ack_i` is 1 at an edge while `trap_pend_o` is 1, `trap_pend_o` drops for one cycle. Exactly one clear bit, the winner's, pulses for one cycle, and that buffer entry is cleared. Losing sources stay buffered.
- R8: While the core traps on every instruction and acknowledges each trap, a halt request is taken on the first decision after it is buffered.
- R9: A synchronous active-high reset clears all buffers, the cause register, the strobe and the clear outputs.
- R10: While `trap_pend_o` is 0, `trap_cause_o` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc_i | input | 7 | Exception request pulses, bit index is priority |
| irq_i | input | NUM_IRQ | Interrupt request pulses, bit index is priority |
| irq_en_i | input | 1 | Global interrupt enable |
| halt_req_i | input | 1 | Debug halt request, held until debug mode |
| debug_mode_i | input | 1 | Core is in debug mode |
| trap_ack_i | input | 1 | Core accepts the pending trap |
| trap_pend_o | output | 1 | A trap is pending |
| trap_cause_o | output | 8 | Registered cause code |
| clr_exc_o | output | 7 | One-cycle clear to the winning exception |
| clr_irq_o | output | NUM_IRQ | One-cycle clear to the winning interrupt |
| clr_halt_o | output | 1 | One-cycle clear when halt is accepted |

## Verification
The halt decision and an exception decision can fall in the same cycle. This is provoked in two ways: by pulsing a halt and a fetch-misaligned exception together, and by holding an illegal-instruction request on every cycle while the bench acknowledges every trap and then raises halt part way through. A behavioural model judges each clock. It checks that 0x63 is registered on the next decision, that it never yields to the illegal cause while debug mode is absent, and that the losing exception is still taken after debug mode begins.

// File: rtl/trap_arb_pkg.sv
package trap_arb_pkg;
  localparam int NUM_EXC = 7;
  localparam int CAUSE_W = 8;
  localparam logic [CAUSE_W-1:0] HALT_CAUSE = 8'h63;
  localparam logic [CAUSE_W-1:0] IRQ_FLAG   = 8'h80;

  // bit position of each exception equals its priority rank
  function automatic logic [CAUSE_W-1:0] exc_cause(input int idx);
    case (idx)
      0:       return 8'h00;
      1:       return 8'h01;
      2:       return 8'h02;
      3:       return 8'h03;
      4:       return 8'h04;
      5:       return 8'h05;
      default: return 8'h0B;
    endcase
  endfunction
endpackage

// File: rtl/trap_src_buf.sv
module trap_src_buf #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic         flush_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)          q_o <= '0;
    else if (flush_i) q_o <= '0;
    else              q_o <= (q_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/trap_prio_pick.sv
module trap_prio_pick #(
  parameter  int W  = 4,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic [W-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    grant_o = '0;
    idx_o   = '0;
    any_o   = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
        idx_o      = IW'(i);
        any_o      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_arb_pkg::*;
#(
  parameter  int NUM_IRQ = 4,
  localparam int EIW = $clog2(NUM_EXC),
  localparam int IIW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_EXC-1:0]  exc_i,
  input  logic [NUM_IRQ-1:0]  irq_i,
  input  logic                irq_en_i,
  input  logic                halt_req_i,
  input  logic                debug_mode_i,
  input  logic                trap_ack_i,
  output logic                trap_pend_o,
  output logic [CAUSE_W-1:0]  trap_cause_o,
  output logic [NUM_EXC-1:0]  clr_exc_o,
  output logic [NUM_IRQ-1:0]  clr_irq_o,
  output logic                clr_halt_o
);
  logic [NUM_EXC-1:0] exc_buf, exc_kill, exc_grant, win_exc, win_exc_q;
  logic [NUM_IRQ-1:0] irq_buf, irq_kill, irq_eff, irq_grant, win_irq, win_irq_q;
  logic [0:0]         halt_buf;
  logic               halt_eff, win_halt, win_halt_q;
  logic [EIW-1:0]     exc_idx;
  logic [IIW-1:0]     irq_idx;
  logic               exc_any, irq_any, take;
  logic [CAUSE_W-1:0] sel_cause;

  assign take     = trap_ack_i & trap_pend_o;
  assign exc_kill = take ? win_exc_q : '0;
  assign irq_kill = take ? win_irq_q : '0;

  trap_src_buf #(.W(NUM_EXC)) u_exc_buf (
    .clk(clk), .rst(rst), .set_i(exc_i), .clr_i(exc_kill),
    .flush_i(1'b0), .q_o(exc_buf));

  trap_src_buf #(.W(NUM_IRQ)) u_irq_buf (
    .clk(clk), .rst(rst), .set_i(irq_i), .clr_i(irq_kill),
    .flush_i(1'b0), .q_o(irq_buf));

  // halt stays until the core reports debug mode
  trap_src_buf #(.W(1)) u_halt_buf (
    .clk(clk), .rst(rst), .set_i(halt_req_i), .clr_i(1'b0),
    .flush_i(debug_mode_i), .q_o(halt_buf));

  assign halt_eff = halt_buf[0] & ~debug_mode_i;
  assign irq_eff  = (irq_en_i & ~debug_mode_i) ? irq_buf : '0;

  trap_prio_pick #(.W(NUM_EXC)) u_exc_pick (
    .req_i(exc_buf), .grant_o(exc_grant), .idx_o(exc_idx), .any_o(exc_any));

  trap_prio_pick #(.W(NUM_IRQ)) u_irq_pick (
    .req_i(irq_eff), .grant_o(irq_grant), .idx_o(irq_idx), .any_o(irq_any));

  always_comb begin
    win_halt  = 1'b0;
    win_exc   = '0;
    win_irq   = '0;
    sel_cause = trap_cause_o;
    if (halt_eff) begin
      win_halt  = 1'b1;
      sel_cause = HALT_CAUSE;
    end else if (exc_any) begin
      win_exc   = exc_grant;
      sel_cause = exc_cause(int'(exc_idx));
    end else if (irq_any) begin
      win_irq   = irq_grant;
      sel_cause = IRQ_FLAG | CAUSE_W'(irq_idx);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_pend_o  <= 1'b0;
      trap_cause_o <= '0;
      win_exc_q    <= '0;
      win_irq_q    <= '0;
      win_halt_q   <= 1'b0;
      clr_exc_o    <= '0;
      clr_irq_o    <= '0;
      clr_halt_o   <= 1'b0;
    end else if (take) begin
      trap_pend_o  <= 1'b0;
      clr_exc_o    <= win_exc_q;
      clr_irq_o    <= win_irq_q;
      clr_halt_o   <= win_halt_q;
    end else begin
      trap_pend_o  <= halt_eff | exc_any | irq_any;
      trap_cause_o <= sel_cause;
      win_exc_q    <= win_exc;
      win_irq_q    <= win_irq;
      win_halt_q   <= win_halt;
      clr_exc_o    <= '0;
      clr_irq_o    <= '0;
      clr_halt_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/trap_arb_chk.sv
module trap_arb_chk
  import trap_arb_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               debug_mode_i,
  input logic               trap_ack_i,
  input logic               trap_pend_o,
  input logic [CAUSE_W-1:0] trap_cause_o,
  input logic [NUM_EXC-1:0] clr_exc_o,
  input logic [NUM_IRQ-1:0] clr_irq_o,
  input logic               clr_halt_o
);
  logic any_clr;
  assign any_clr = (|clr_exc_o) | (|clr_irq_o) | clr_halt_o;

  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $onehot0({clr_exc_o, clr_irq_o, clr_halt_o})); // R7

  AST_CLEAR_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    any_clr |-> $past(trap_ack_i && trap_pend_o)); // R7

  AST_PEND_DROPS: assert property (@(posedge clk) disable iff (rst)
    (trap_ack_i && trap_pend_o) |=> !trap_pend_o); // R7

  AST_DEBUG_MASK: assert property (@(posedge clk) disable iff (rst)
    (trap_pend_o && $past(debug_mode_i) && !$past(trap_ack_i && trap_pend_o))
      |-> (!trap_cause_o[CAUSE_W-1] && trap_cause_o != HALT_CAUSE)); // R5

  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !trap_pend_o |-> $stable(trap_cause_o)); // R10

  AST_HALT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr_halt_o |-> $past(trap_cause_o == HALT_CAUSE)); // R8

  AST_HALT_STICKS: assert property (@(posedge clk) disable iff (rst)
    ($past(trap_pend_o && trap_cause_o == HALT_CAUSE) && !$past(trap_ack_i)
      && !$past(debug_mode_i)) |-> (trap_pend_o && trap_cause_o == HALT_CAUSE)); // R2
endmodule

bind trap_arbiter trap_arb_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst(rst), .debug_mode_i(debug_mode_i), .trap_ack_i(trap_ack_i),
  .trap_pend_o(trap_pend_o), .trap_cause_o(trap_cause_o), .clr_exc_o(clr_exc_o),
  .clr_irq_o(clr_irq_o), .clr_halt_o(clr_halt_o));

// File: tb/trap_arbiter_bench.sv
module trap_arbiter_bench;
  import trap_arb_pkg::*;
  localparam int NI = 4;
  localparam int NONE = -1;
  localparam int HALT_ID = 99;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1;
  logic [NUM_EXC-1:0] exc_i = '0;
  logic [NI-1:0] irq_i = '0;
  logic irq_en_i = 1'b0, halt_req_i = 1'b0, debug_mode_i = 1'b0, trap_ack_i = 1'b0;
  logic trap_pend_o, clr_halt_o;
  logic [CAUSE_W-1:0] trap_cause_o;
  logic [NUM_EXC-1:0] clr_exc_o;
  logic [NI-1:0] clr_irq_o;

  trap_arbiter #(.NUM_IRQ(NI)) u_trap_arbiter (
    .clk(clk), .rst(rst), .exc_i(exc_i), .irq_i(irq_i), .irq_en_i(irq_en_i),
    .halt_req_i(halt_req_i), .debug_mode_i(debug_mode_i), .trap_ack_i(trap_ack_i),
    .trap_pend_o(trap_pend_o), .trap_cause_o(trap_cause_o), .clr_exc_o(clr_exc_o),
    .clr_irq_o(clr_irq_o), .clr_halt_o(clr_halt_o));

  int vectors = 0, miscompares = 0;
  string cur_req = "R9";
  bit auto_ack = 0;

  // behavioural model state
  int m_exc[NUM_EXC];
  int m_irq[NI];
  int m_halt = 0, m_pend = 0, m_cause = 0, m_win = NONE, m_clr = NONE;

  function automatic int code_of(int id);
    if (id == HALT_ID) return 'h63;
    if (id >= 10) return 'h80 + id - 10;
    if (id == 6) return 'h0B;
    return id;
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  task automatic step();
    int sel, n_exc[NUM_EXC], n_irq[NI], n_halt;
    bit acked;
    sel = NONE;
    if (m_halt != 0 && !debug_mode_i) sel = HALT_ID;
    for (int i = 0; i < NUM_EXC; i++) if (sel == NONE && m_exc[i] != 0) sel = i;
    if (irq_en_i && !debug_mode_i)
      for (int i = 0; i < NI; i++) if (sel == NONE && m_irq[i] != 0) sel = 10 + i;
    acked = (m_pend != 0) && trap_ack_i;
    for (int i = 0; i < NUM_EXC; i++)
      n_exc[i] = ((m_exc[i] != 0 && !(acked && m_win == i)) || exc_i[i]) ? 1 : 0;
    for (int i = 0; i < NI; i++)
      n_irq[i] = ((m_irq[i] != 0 && !(acked && m_win == 10 + i)) || irq_i[i]) ? 1 : 0;
    n_halt = debug_mode_i ? 0 : ((m_halt != 0 || halt_req_i) ? 1 : 0);
    @(posedge clk);
    if (rst) begin
      foreach (m_exc[i]) m_exc[i] = 0;
      foreach (m_irq[i]) m_irq[i] = 0;
      m_halt = 0; m_pend = 0; m_cause = 0; m_win = NONE; m_clr = NONE;
    end else begin
      m_exc = n_exc; m_irq = n_irq; m_halt = n_halt;
      if (acked) begin
        m_pend = 0; m_clr = m_win;
      end else begin
        m_pend = (sel != NONE) ? 1 : 0;
        if (sel != NONE) m_cause = code_of(sel);
        m_win = sel; m_clr = NONE;
      end
    end
    @(negedge clk);
    begin
      logic [NUM_EXC-1:0] ece;
      logic [NI-1:0] eci;
      logic ech;
      ece = '0; eci = '0;
      for (int i = 0; i < NUM_EXC; i++) ece[i] = (m_clr == i);
      for (int i = 0; i < NI; i++) eci[i] = (m_clr == 10 + i);
      ech = (m_clr == HALT_ID);
      vectors++;
      if (trap_pend_o !== m_pend[0] || trap_cause_o !== CAUSE_W'(m_cause) ||
          clr_exc_o !== ece || clr_irq_o !== eci || clr_halt_o !== ech) begin
        miscompares++;
        $display("FAIL %s t=%0t: actual pend=%b cause=%h clr=%b/%b/%b expected pend=%0d cause=%h clr=%b/%b/%b",
                 cur_req, $time, trap_pend_o, trap_cause_o, clr_exc_o, clr_irq_o, clr_halt_o,
                 m_pend, m_cause[CAUSE_W-1:0], ece, eci, ech);
      end
    end
    if (auto_ack) trap_ack_i = trap_pend_o;
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    miscompares++;
    $display("FAIL R6 watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    foreach (m_exc[i]) m_exc[i] = 0;
    foreach (m_irq[i]) m_irq[i] = 0;
    @(negedge clk);
    cur_req = "R9"; run(3);
    rst = 1'b0;
    // R1 / R6: each exception alone, with its code and latency
    cur_req = "R1";
    for (int e = 0; e < NUM_EXC; e++) begin
      exc_i = NUM_EXC'(1) << e; step(); exc_i = '0;
      cur_req = "R6"; run(2);
      trap_ack_i = 1'b1; step(); trap_ack_i = 1'b0; run(2);
      cur_req = "R1";
    end
    // R3: several exceptions together drain in bit order
    cur_req = "R3";
    exc_i = 7'b1111100; step(); exc_i = '0;
    auto_ack = 1; run(16); auto_ack = 0; trap_ack_i = 1'b0; run(2);
    // R2 / R7: halt and misaligned fetch in the same cycle
    cur_req = "R2";
    exc_i = 7'b0000001; halt_req_i = 1'b1; step(); exc_i = '0; run(4);
    cur_req = "R7";
    trap_ack_i = 1'b1; step(); trap_ack_i = 1'b0; run(2);
    // R5: debug mode masks halt and interrupts; losing exception is taken
    cur_req = "R5";
    debug_mode_i = 1'b1; irq_en_i = 1'b1; irq_i = 4'b0001; step(); irq_i = '0;
    auto_ack = 1; run(8); auto_ack = 0; trap_ack_i = 1'b0; run(2);
    halt_req_i = 1'b0; step(); debug_mode_i = 1'b0;
    // R4: pending interrupt taken after debug exit, exceptions outrank
    cur_req = "R4";
    auto_ack = 1; run(6); auto_ack = 0; trap_ack_i = 1'b0; run(1);
    irq_en_i = 1'b0; irq_i = 4'b0110; step(); irq_i = '0; run(4);
    exc_i = 7'b1000000; step(); exc_i = '0; run(3);
    irq_en_i = 1'b1; auto_ack = 1; run(12); auto_ack = 0; trap_ack_i = 1'b0; run(2);
    // R8: endless illegal-instruction loop, then halt
    cur_req = "R8";
    exc_i = 7'b0000100; auto_ack = 1; run(10);
    halt_req_i = 1'b1; run(10);
    debug_mode_i = 1'b1; step(); halt_req_i = 1'b0; exc_i = '0; run(6);
    auto_ack = 0; trap_ack_i = 1'b0; debug_mode_i = 1'b0; run(2);
    // R10: idle cause hold
    cur_req = "R10";
    run(6);
    summary();
  end
endmodule